// File: doc/BRIEF.md
# Pseudo-SRAM Power-Mode Sequencer

This block owns the two chip-enable lines of a pseudo-SRAM during power-up, standby and deep power-down. After the supply is reported good, it holds the memory in its initialisation wait. During that wait the secondary enable stays high and the primary enable is forced inactive. The block then grants access by raising a ready flag. While ready is high, the primary enable is passed through from the access controller. Outside that phase the primary enable is forced inactive.

A sleep request is taken only while the access controller reports idle. The sequencer then withdraws ready and keeps the primary enable inactive for a guard interval. After that it pulls the secondary enable low, which places the memory in deep power-down. A wake request raises the secondary enable again and reruns the full initialisation wait. Any departure from deep power-down sets a sticky flag, because the array contents are no longer valid. The host clears this flag with a pulse.

All intervals are parameters. They are given in microseconds and turned into clock cycles from the clock frequency in MHz. The initialisation wait is INIT = CLK_MHZ*INIT_US cycles and the guard is GUARD = CLK_MHZ*GUARD_US cycles.

Top module: `psram_pwr_seq`

## Requirements
- R1: While rst_n is low: ce2_o=1, ce1_n_o=1, ready_o=0, data_lost_o=0.
- R2: Any clock edge that samples pwr_good_i low puts the block in its off phase from the next cycle, whatever the phase before. In the off phase ce2_o=1, ce1_n_o=1 and ready_o=0.
- R3: The edge that first samples pwr_good_i high in the off phase starts the initialisation wait. During the wait ce2_o=1, ce1_n_o=1 and ready_o=0. ready_o rises on the INIT-th edge after that starting edge.
- R4: While ready_o=1, ce2_o=1 and ce1_n_o equals acc_ce1_n_i in the same cycle. While ready_o=0, ce1_n_o is 1 regardless of acc_ce1_n_i.
- R5: An edge that samples sleep_req_i=1 and ctrl_idle_i=1 while ready_o=1 drops ready_o and starts the guard. ce2_o falls GUARD edges later. A sleep request with ctrl_idle_i=0 has no effect.
- R6: In deep power-down, ce2_o=0, ce1_n_o=1 and ready_o=0. This state holds for as long as no wake request is accepted and pwr_good_i stays high.
- R7: A wake request is ignored until ce2_o has been low for GUARD cycles. An accepted wake request raises ce2_o from the next cycle. ready_o then returns INIT edges after the accepting edge.
- R8: data_lost_o is set on every exit from deep power-down, whether by wake or by power loss. It stays set until an edge samples lost_clr_i=1. When set and clear occur on the same edge, set wins.
- R9: wake_req_i outside deep power-down has no effect, and neither does sleep_req_i outside the ready phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_good_i | input | 1 | Memory supply is within range |
| sleep_req_i | input | 1 | Request to enter deep power-down |
| wake_req_i | input | 1 | Request to leave deep power-down |
| ctrl_idle_i | input | 1 | Access controller has no access in flight |
| acc_ce1_n_i | input | 1 | Primary enable wanted by the access controller (active low) |
| lost_clr_i | input | 1 | Clears the data-lost flag |
| ce2_o | output | 1 | Secondary chip enable; low means deep power-down |
| ce1_n_o | output | 1 | Primary chip enable to the memory (active low) |
| ready_o | output | 1 | Accesses are allowed |
| data_lost_o | output | 1 | Sticky: array contents invalid since the last clear |

## Verification
The bench builds the block with CLK_MHZ=1, INIT_US=20 and GUARD_US=3, which gives a 20-cycle initialisation wait and a 3-cycle guard. With an interval this short, the bench can count the exact edge at which ready returns, several times in one run. A guard of three cycles lets a wake request land inside the minimum deep-power-down dwell and be seen to be ignored. It also leaves room for power loss during the wait, during operation and during deep power-down, and for set and clear of the loss flag on the same edge.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_INIT,
        PS_ACTIVE,
        PS_SUSPEND,
        PS_DEEP
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        logic       ready;
        logic       ce2;
        logic       ce1_hold;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:    PS_OFF,
        ready:    1'b0,
        ce2:      1'b1,
        ce1_hold: 1'b1
    };

    function automatic int unsigned us_to_cycles(input int unsigned mhz, input int unsigned us);
        return mhz * us;
    endfunction

endpackage

// File: rtl/psram_pwr_timer.sv
module psram_pwr_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

    // R7
    tmr_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7
    tmr_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/psram_loss_flag.sv
module psram_loss_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i) begin
            flag_d = 1'b1;
        end else if (clr_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    // R8
    loss_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(set_i));

    // R8
    loss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 125,
    parameter int unsigned INIT_US  = 200,
    parameter int unsigned GUARD_US = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_i,
    input  logic sleep_req_i,
    input  logic wake_req_i,
    input  logic ctrl_idle_i,
    input  logic acc_ce1_n_i,
    input  logic lost_clr_i,
    output logic ce2_o,
    output logic ce1_n_o,
    output logic ready_o,
    output logic data_lost_o
);

    localparam int unsigned INIT_CYC  = us_to_cycles(CLK_MHZ, INIT_US);
    localparam int unsigned GUARD_CYC = us_to_cycles(CLK_MHZ, GUARD_US);
    localparam int unsigned MAX_CYC   = (INIT_CYC > GUARD_CYC) ? INIT_CYC : GUARD_CYC;
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] INIT_LOAD  = CNT_W'(INIT_CYC - 1);
    localparam logic [CNT_W-1:0] GUARD_LOAD = CNT_W'(GUARD_CYC - 1);

    seq_regs_t        seq_d, seq_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             lost_set;

    psram_pwr_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .done_o    (tmr_done)
    );

    psram_loss_flag u_loss (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (lost_set),
        .clr_i (lost_clr_i),
        .flag_o(data_lost_o)
    );

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        lost_set = 1'b0;

        unique case (seq_q.state)
            PS_OFF: begin
                if (pwr_good_i) begin
                    seq_d.state = PS_INIT;
                    tmr_load    = 1'b1;
                    tmr_val     = INIT_LOAD;
                end
            end
            PS_INIT: begin
                if (tmr_done) begin
                    seq_d.state = PS_ACTIVE;
                end
            end
            PS_ACTIVE: begin
                if (sleep_req_i && ctrl_idle_i) begin
                    seq_d.state = PS_SUSPEND;
                    tmr_load    = 1'b1;
                    tmr_val     = GUARD_LOAD;
                end
            end
            PS_SUSPEND: begin
                if (tmr_done) begin
                    seq_d.state = PS_DEEP;
                    tmr_load    = 1'b1;
                    tmr_val     = GUARD_LOAD;
                end
            end
            PS_DEEP: begin
                if (tmr_done && wake_req_i) begin
                    seq_d.state = PS_INIT;
                    tmr_load    = 1'b1;
                    tmr_val     = INIT_LOAD;
                    lost_set    = 1'b1;
                end
            end
            default: begin
                seq_d.state = PS_OFF;
            end
        endcase

        if (!pwr_good_i) begin
            if (seq_q.state == PS_DEEP) begin
                lost_set = 1'b1;
            end
            seq_d.state = PS_OFF;
            tmr_load    = 1'b0;
        end

        seq_d.ready    = (seq_d.state == PS_ACTIVE);
        seq_d.ce2      = (seq_d.state != PS_DEEP);
        seq_d.ce1_hold = (seq_d.state != PS_ACTIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ce2_o   = seq_q.ce2;
    assign ready_o = seq_q.ready;
    assign ce1_n_o = seq_q.ce1_hold | acc_ce1_n_i;

    // R2
    pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |=> (!ready_o && ce2_o && ce1_n_o));

    // R3
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(seq_q.state) == PS_INIT && $past(tmr_done) && $past(pwr_good_i)));

    // R4
    ready_ce2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> ce2_o);

    // R5
    ce2_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce2_o) |-> ($past(seq_q.state) == PS_SUSPEND && $past(tmr_done)));

    // R6
    deep_ce1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce2_o |-> (ce1_n_o && !ready_o));

    // R7
    wake_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce2_o) |-> ($past(tmr_done) || !$past(pwr_good_i)));

endmodule

// File: tb/psram_pwr_seq_tb.sv
module psram_pwr_seq_tb;

    localparam int MHZ     = 1;
    localparam int IUS     = 20;
    localparam int GUS     = 3;
    localparam int INIT_N  = MHZ * IUS;
    localparam int GUARD_N = MHZ * GUS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic sleep_req = 1'b0;
    logic wake_req = 1'b0;
    logic ctrl_idle = 1'b0;
    logic acc_ce1_n = 1'b1;
    logic lost_clr = 1'b0;
    logic ce2, ce1_n, ready, data_lost;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    int m_state = 0;   // 0 off, 1 init wait, 2 ready, 3 guard, 4 deep
    int m_cnt = 0;
    bit m_lost = 1'b0;

    psram_pwr_seq #(
        .CLK_MHZ (MHZ),
        .INIT_US (IUS),
        .GUARD_US(GUS)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good_i (pwr_good),
        .sleep_req_i(sleep_req),
        .wake_req_i (wake_req),
        .ctrl_idle_i(ctrl_idle),
        .acc_ce1_n_i(acc_ce1_n),
        .lost_clr_i (lost_clr),
        .ce2_o      (ce2),
        .ce1_n_o    (ce1_n),
        .ready_o    (ready),
        .data_lost_o(data_lost)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin : model
        bit set_now;
        set_now = 1'b0;
        if (!rst_n) begin
            m_state = 0;
            m_cnt   = 0;
            m_lost  = 1'b0;
        end else begin
            if (!pwr_good) begin
                if (m_state == 4) set_now = 1'b1;
                m_state = 0;
            end else begin
                case (m_state)
                    0: begin m_state = 1; m_cnt = INIT_N; end
                    1: begin m_cnt--; if (m_cnt == 0) m_state = 2; end
                    2: if (sleep_req && ctrl_idle) begin m_state = 3; m_cnt = GUARD_N; end
                    3: begin m_cnt--; if (m_cnt == 0) begin m_state = 4; m_cnt = GUARD_N - 1; end end
                    default: begin
                        if (m_cnt > 0) m_cnt--;
                        else if (wake_req) begin m_state = 1; m_cnt = INIT_N; set_now = 1'b1; end
                    end
                endcase
            end
            if (set_now) m_lost = 1'b1;
            else if (lost_clr) m_lost = 1'b0;
        end
    end

    // lock-step comparison, every cycle
    always begin : compare
        string tag;
        @(negedge clk);
        #1;
        case (m_state)
            0: tag = rst_n ? "R2" : "R1";
            1: tag = "R3";
            2: tag = "R4";
            3: tag = "R5";
            default: tag = "R6";
        endcase
        chk(tag, "ce2", int'(ce2), (m_state != 4) ? 1 : 0);
        chk(tag, "ready", int'(ready), (m_state == 2) ? 1 : 0);
        chk(tag, "ce1_n", int'(ce1_n), (m_state == 2) ? int'(acc_ce1_n) : 1);
        chk("R8", "data_lost", int'(data_lost), int'(m_lost));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_to_ready(input int start, output int n);
        n = start;
        while (!ready && n < 500) begin
            tick(1);
            #2;
            n++;
        end
    endtask

    task automatic summary;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : stim
        int n;
        tick(3);
        #2;
        chk("R1", "ce2 in reset", int'(ce2), 1);
        chk("R1", "ce1_n in reset", int'(ce1_n), 1);
        chk("R1", "ready in reset", int'(ready), 0);
        chk("R1", "lost in reset", int'(data_lost), 0);
        rst_n = 1'b1;
        tick(4);
        #2;
        chk("R2", "ready without power", int'(ready), 0);
        chk("R2", "ce2 without power", int'(ce2), 1);

        // R3 power-up wait length
        pwr_good = 1'b1;
        count_to_ready(0, n);
        chk("R3", "cycles to ready", n, INIT_N + 1);

        // R4 pass-through of primary enable
        acc_ce1_n = 1'b0;
        #1;
        chk("R4", "ce1_n follows", int'(ce1_n), 0);
        acc_ce1_n = 1'b1;
        #1;
        chk("R4", "ce1_n follows high", int'(ce1_n), 1);

        // R5 sleep refused while busy
        sleep_req = 1'b1;
        ctrl_idle = 1'b0;
        tick(3);
        #2;
        chk("R5", "ready while busy sleep", int'(ready), 1);
        sleep_req = 1'b0;

        // R9 wake outside deep power-down
        wake_req = 1'b1;
        tick(2);
        #2;
        chk("R9", "ready after stray wake", int'(ready), 1);
        chk("R9", "ce2 after stray wake", int'(ce2), 1);
        wake_req = 1'b0;

        // R5 accepted sleep and guard
        sleep_req = 1'b1;
        ctrl_idle = 1'b1;
        acc_ce1_n = 1'b0;
        tick(1);
        #2;
        sleep_req = 1'b0;
        chk("R5", "ready after sleep", int'(ready), 0);
        chk("R4", "ce1_n forced", int'(ce1_n), 1);
        chk("R5", "ce2 in guard", int'(ce2), 1);
        tick(GUARD_N - 1);
        #2;
        chk("R5", "ce2 end of guard", int'(ce2), 1);
        tick(1);
        #2;
        chk("R5", "ce2 falls", int'(ce2), 0);

        // R7 early wake ignored
        wake_req = 1'b1;
        tick(1);
        #2;
        wake_req = 1'b0;
        chk("R7", "ce2 after early wake", int'(ce2), 0);
        sleep_req = 1'b1;
        tick(GUARD_N + 2);
        #2;
        sleep_req = 1'b0;
        chk("R9", "ce2 after sleep in deep", int'(ce2), 0);
        chk("R6", "ready in deep", int'(ready), 0);
        chk("R6", "ce1_n in deep", int'(ce1_n), 1);
        chk("R8", "lost before exit", int'(data_lost), 0);

        // R7 accepted wake, R8 loss flag
        wake_req = 1'b1;
        tick(1);
        #2;
        wake_req = 1'b0;
        chk("R7", "ce2 after wake", int'(ce2), 1);
        chk("R7", "ready after wake", int'(ready), 0);
        chk("R8", "lost after wake", int'(data_lost), 1);
        count_to_ready(1, n);
        chk("R7", "cycles to ready after wake", n, INIT_N + 1);
        chk("R8", "lost persists", int'(data_lost), 1);
        lost_clr = 1'b1;
        tick(1);
        #2;
        lost_clr = 1'b0;
        chk("R8", "lost cleared", int'(data_lost), 0);

        // R8 set wins over clear
        sleep_req = 1'b1;
        tick(1);
        #2;
        sleep_req = 1'b0;
        tick(2 * GUARD_N);
        #2;
        chk("R6", "ce2 low again", int'(ce2), 0);
        wake_req = 1'b1;
        lost_clr = 1'b1;
        tick(1);
        #2;
        wake_req = 1'b0;
        lost_clr = 1'b0;
        chk("R8", "set beats clear", int'(data_lost), 1);
        lost_clr = 1'b1;
        tick(1);
        #2;
        lost_clr = 1'b0;
        chk("R8", "clear after set", int'(data_lost), 0);
        count_to_ready(0, n);

        // R2 power loss while ready and during the wait
        pwr_good = 1'b0;
        tick(1);
        #2;
        chk("R2", "ready after power loss", int'(ready), 0);
        chk("R2", "ce1_n after power loss", int'(ce1_n), 1);
        pwr_good = 1'b1;
        tick(3);
        #2;
        pwr_good = 1'b0;
        tick(1);
        #2;
        chk("R2", "ce2 after loss in wait", int'(ce2), 1);
        pwr_good = 1'b1;
        count_to_ready(0, n);
        chk("R3", "cycles to ready after restart", n, INIT_N + 1);

        // R8 power loss in deep power-down
        sleep_req = 1'b1;
        tick(1);
        #2;
        sleep_req = 1'b0;
        tick(GUARD_N + 1);
        #2;
        chk("R6", "in deep before loss", int'(ce2), 0);
        pwr_good = 1'b0;
        tick(1);
        #2;
        chk("R8", "lost after power loss in deep", int'(data_lost), 1);
        chk("R2", "ce2 high after loss in deep", int'(ce2), 1);
        pwr_good = 1'b1;
        count_to_ready(0, n);
        chk("R3", "ready after loss in deep", int'(ready), 1);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule